// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block sits on the programmer side of an in-system flash programming link. It drives the target's reset, serial clock and serial data-out lines and reads the serial data-in line. It brings the target into programming mode and then writes a stream of 16-bit program words into flash, one page at a time. After power-up it holds reset and the serial clock low. It gives the target a reset pulse, waits out a settling time, and then sends the 4-byte programming-enable instruction. It checks the byte the target returns during the third byte of that instruction.

A missing echo means the bit stream is out of step with the target. The sequencer then pulses reset again and retries the enable. It gives up with an error after a set number of failed attempts. Once enabled, it accepts words on a valid/ready stream. Each word goes out as two load instructions, low byte first, at its in-page word slot. After the last slot of a page, or after the word flagged last, it issues a page-write instruction. It then either polls the target's busy bit or waits a fixed write time before the next page. A sticky done or error flag ends the run.

Top module: `isp_host_seq`

## Requirements
- R1: While reset is asserted, tgt_rst_o, sck_o, in_ready_o, done_o and error_o are all 0.
- R2: Before every enable attempt, tgt_rst_o is high for exactly RST_PULSE clocks while sck_o is low. sck_o is never high while tgt_rst_o is high.
- R3: After the reset pulse ends, the first rising edge of sck_o comes no earlier than SETTLE_CYC clocks later.
- R4: The enable frame is the 32 bits 0xAC 0x53 0x00 0x00, sent MSB first and always sent in full. Target data is sampled on each rising sck_o. Enable succeeds only when the byte read back during the third byte equals 0x53.
- R5: A failed echo causes a new reset pulse and a new enable frame. When MAX_TRIES attempts have failed, error_o goes high and stays high. After that no frame is sent and in_ready_o stays 0.
- R6: Each accepted word i (counted from 0) sends the frame 0x40 0x00 {i[4:0]} data[7:0], then the frame 0x48 0x00 {i[4:0]} data[15:8].
- R7: After the high-byte frame of a word whose index has i[4:0] = 31, or of the word that had in_last_i set, the block sends the frame 0x4C, then a 16-bit page base word address (the word index with bits [4:0] cleared), then 0x00.
- R8: When USE_POLL = 1, each page write is followed by frames 0xF0 0x00 0x00 0x00. These repeat while bit 0 of the byte read during the fourth byte is 1. No load frame is sent before that bit reads 0.
- R9: When USE_POLL = 0, no poll frame is sent. At least WRITE_CYC clocks pass between the last rising sck_o of a page write and the next rising sck_o.
- R10: sck_o stays high for exactly SCK_HALF clocks per bit. mosi_o changes only while sck_o is low.
- R11: in_ready_o is high only while the block waits for a word and no frame is running. done_o rises after the final page is committed and stays high, with no further frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Program word valid |
| in_data_i | input | 16 | Program word |
| in_last_i | input | 1 | Marks the final word of the image |
| in_ready_o | output | 1 | Word accepted when high with valid |
| tgt_rst_o | output | 1 | Target reset line (high = pulse) |
| sck_o | output | 1 | Serial clock to target |
| mosi_o | output | 1 | Serial data to target |
| miso_i | input | 1 | Serial data from target |
| done_o | output | 1 | Image fully written (sticky) |
| error_o | output | 1 | Enable attempts exhausted (sticky) |

## Verification
The delicate cycle is the echo verdict on an enable frame, because it also decides whether the attempt limit has been reached. The same echo failure has to cause a retry on one attempt and a stop on the next. A model target corrupts the echo on a chosen number of attempts: one fewer than the limit, which must recover, and exactly the limit, which must stop with no later frames. A second point of coincidence is a stream that ends on exactly the last slot of a page. Both the full-page rule and the last-word rule then call for the same single page write. The frame log recorded by the target model is compared frame by frame with a list the bench builds from the requirements.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [3:0] {
    S_PWR, S_PULSE, S_SETTLE, S_EN, S_WAIT_W, S_LO, S_HI,
    S_WR, S_POLL, S_HOLD, S_DONE, S_ERR
  } seq_st_e;

  localparam logic [7:0] OP_EN    = 8'hAC;
  localparam logic [7:0] EN_ECHO  = 8'h53;
  localparam logic [7:0] OP_LD_LO = 8'h40;
  localparam logic [7:0] OP_LD_HI = 8'h48;
  localparam logic [7:0] OP_WR_PG = 8'h4C;
  localparam logic [7:0] OP_POLL  = 8'hF0;
endpackage

// File: rtl/isp_timer.sv
module isp_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/isp_frame.sv
module isp_frame #(
  parameter int HALF = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] tx_i,
  input  logic        miso_i,
  output logic        sck_o,
  output logic        mosi_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] rx_o
);
  localparam int DIV_W = $clog2(HALF + 1);

  logic [DIV_W-1:0] div_q;
  logic [4:0]       bit_q;
  logic [31:0]      tx_q, rx_q;
  logic             busy_q, sck_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; bit_q <= '0; tx_q <= '0; rx_q <= '0;
      busy_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1; tx_q <= tx_i; div_q <= '0; bit_q <= '0;
        end
      end else if (div_q == DIV_W'(HALF - 1)) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[30:0], miso_i};
        end else begin
          // data advances on the falling edge, so it only moves while sck is low
          sck_q <= 1'b0;
          tx_q  <= {tx_q[30:0], 1'b0};
          bit_q <= bit_q + 5'd1;
          if (bit_q == 5'd31) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[31];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  AST_MOSI_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> !sck_o); // R10
  AST_IDLE_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_o); // R10
  if (HALF >= 2) begin : g_hold
    AST_SCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sck_o) |=> $stable(sck_o)); // R10
  end
endmodule

// File: rtl/isp_host_seq.sv
module isp_host_seq
  import isp_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int RST_PULSE  = 4,
  parameter int SETTLE_CYC = 2_000_000,
  parameter int MAX_TRIES  = 3,
  parameter int WRITE_CYC  = 450_000,
  parameter bit USE_POLL   = 1'b1,
  parameter int ADDR_W     = 11,
  parameter int PG_W       = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [15:0] in_data_i,
  input  logic        in_last_i,
  output logic        in_ready_o,
  output logic        tgt_rst_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        done_o,
  output logic        error_o
);
  localparam int MAX_A = (RST_PULSE > SETTLE_CYC) ? RST_PULSE : SETTLE_CYC;
  localparam int MAXC  = (MAX_A > WRITE_CYC) ? MAX_A : WRITE_CYC;
  localparam int TW    = $clog2(MAXC + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  seq_st_e st_q, st_d;
  logic [TRY_W-1:0]  tries_q;
  logic [ADDR_W-1:0] addr_q, cur_q;
  logic [15:0]       wd_q;
  logic              last_q, sent_q;

  logic          tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          fr_start, fr_busy, fr_done;
  logic [31:0]   fr_tx, fr_rx;
  logic          frame_st, echo_ok, last_try, page_end, tgt_busy;
  logic [15:0]   pg_base;
  logic          unused_rx;

  isp_timer #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  isp_frame #(.HALF(SCK_HALF)) u_frame (
    .clk_i, .rst_ni, .start_i(fr_start), .tx_i(fr_tx), .miso_i,
    .sck_o, .mosi_o, .busy_o(fr_busy), .done_o(fr_done), .rx_o(fr_rx)
  );

  assign echo_ok   = (fr_rx[15:8] == EN_ECHO);
  assign tgt_busy  = fr_rx[0];
  assign unused_rx = ^{fr_rx[31:16], fr_rx[7:1]};
  assign last_try  = (tries_q == TRY_W'(MAX_TRIES - 1));
  assign page_end  = (&cur_q[PG_W-1:0]) || last_q;
  assign pg_base   = 16'({cur_q[ADDR_W-1:PG_W], PG_W'(0)});
  assign frame_st  = st_q inside {S_EN, S_LO, S_HI, S_WR, S_POLL};
  assign fr_start  = frame_st && !sent_q && !fr_busy;

  always_comb begin
    unique case (st_q)
      S_LO:    fr_tx = {OP_LD_LO, 8'h00, 8'(cur_q[PG_W-1:0]), wd_q[7:0]};
      S_HI:    fr_tx = {OP_LD_HI, 8'h00, 8'(cur_q[PG_W-1:0]), wd_q[15:8]};
      S_WR:    fr_tx = {OP_WR_PG, pg_base, 8'h00};
      S_POLL:  fr_tx = {OP_POLL, 24'h0};
      default: fr_tx = {OP_EN, EN_ECHO, 16'h0};
    endcase
  end

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      S_PWR: begin
        st_d = S_PULSE; tmr_ld = 1'b1; tmr_val = TW'(RST_PULSE - 1);
      end
      S_PULSE: if (tmr_zero) begin
        st_d = S_SETTLE; tmr_ld = 1'b1; tmr_val = TW'(SETTLE_CYC - 1);
      end
      S_SETTLE: if (tmr_zero) st_d = S_EN;
      S_EN: if (fr_done) begin
        if (echo_ok)       st_d = S_WAIT_W;
        else if (last_try) st_d = S_ERR;
        else begin
          st_d = S_PULSE; tmr_ld = 1'b1; tmr_val = TW'(RST_PULSE - 1);
        end
      end
      S_WAIT_W: if (in_valid_i) st_d = S_LO;
      S_LO:     if (fr_done) st_d = S_HI;
      S_HI:     if (fr_done) st_d = page_end ? S_WR : S_WAIT_W;
      S_WR: if (fr_done) begin
        if (USE_POLL) st_d = S_POLL;
        else begin
          st_d = S_HOLD; tmr_ld = 1'b1; tmr_val = TW'(WRITE_CYC - 1);
        end
      end
      S_POLL: if (fr_done && !tgt_busy) st_d = last_q ? S_DONE : S_WAIT_W;
      S_HOLD: if (tmr_zero) st_d = last_q ? S_DONE : S_WAIT_W;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_PWR; tries_q <= '0; addr_q <= '0; cur_q <= '0;
      wd_q <= '0; last_q <= 1'b0; sent_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (fr_start)     sent_q <= 1'b1;
      else if (fr_done) sent_q <= 1'b0;
      if (st_q == S_EN && fr_done && !echo_ok) tries_q <= tries_q + 1'b1;
      if (st_q == S_WAIT_W && in_valid_i) begin
        wd_q <= in_data_i; last_q <= in_last_i; cur_q <= addr_q;
      end
      if (st_q == S_HI && fr_done) addr_q <= cur_q + 1'b1;
    end
  end

  assign in_ready_o = (st_q == S_WAIT_W);
  assign tgt_rst_o  = (st_q == S_PULSE);
  assign done_o     = (st_q == S_DONE);
  assign error_o    = (st_q == S_ERR);

  AST_RST_NO_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_o |-> !sck_o); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o && !in_ready_o && !fr_busy); // R5
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !fr_busy); // R11
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !fr_busy); // R11
  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o)); // R5
endmodule

// File: tb/tb_isp_host_seq.sv
`timescale 1ns/1ps
module tgt_model #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic trst,
  input  logic sck,
  input  logic mosi,
  input  int   bad_n,
  input  int   busy_n,
  output logic miso
);
  logic [31:0] frames [256];
  int nfr, pulses, pw_min, pw_max, st_min, wg_min, hi_bad, mc_bad, rs_bad, n_en;
  int rlen, slen, hlen, wlen, bc, busy_left;
  bit sarm, warm, p_sck, p_rst, p_mosi;
  logic [31:0] sh;
  logic [7:0]  ob;

  function automatic logic [7:0] outb(int k);
    if (k == 1) return sh[7:0];
    if (k == 2) return (sh[15:8] == 8'hAC && n_en < bad_n) ? 8'hFF : sh[7:0];
    if (k == 3) return (sh[23:16] == 8'hF0) ? {7'b0, busy_left > 0} : sh[7:0];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      nfr = 0; pulses = 0; pw_min = 32'h7fffffff; pw_max = 0;
      st_min = 32'h7fffffff; wg_min = 32'h7fffffff;
      hi_bad = 0; mc_bad = 0; rs_bad = 0; n_en = 0;
      rlen = 0; slen = 0; hlen = 0; wlen = 0; bc = 0; busy_left = 0;
      sarm = 0; warm = 0; p_sck = 0; p_rst = 0; p_mosi = 0; sh = '0; ob = '0;
      miso <= 1'b0;
    end else begin
      if (trst && sck) rs_bad++;
      if (trst) begin
        rlen++; bc = 0; sh = '0;
      end else if (p_rst) begin
        pulses++;
        if (rlen < pw_min) pw_min = rlen;
        if (rlen > pw_max) pw_max = rlen;
        rlen = 0; sarm = 1; slen = 0;
      end
      if (sarm) slen++;
      if (warm) wlen++;
      if (sck) hlen++;
      if (sck && p_sck && mosi != p_mosi) mc_bad++;
      if (sck && !p_sck) begin
        if (sarm) begin if (slen < st_min) st_min = slen; sarm = 0; end
        if (warm) begin if (wlen < wg_min) wg_min = wlen; warm = 0; end
        sh = {sh[30:0], mosi};
        bc++;
        if (bc == 32) begin
          bc = 0;
          if (nfr < 256) frames[nfr] = sh;
          nfr++;
          if (sh[31:24] == 8'hAC) n_en++;
          if (sh[31:24] == 8'h4C) begin busy_left = busy_n; warm = 1; wlen = 0; end
          if (sh[31:24] == 8'hF0 && busy_left > 0) busy_left--;
        end
      end
      if (!sck && p_sck) begin
        if (hlen != HALF) hi_bad++;
        hlen = 0;
        if (bc % 8 == 0) ob = outb(bc / 8);
        miso <= ob[7 - (bc % 8)];
      end
      p_sck = sck; p_rst = trst; p_mosi = mosi;
    end
  end
endmodule

module tb_isp_host_seq;
  localparam int HALF   = 2;
  localparam int RSTP   = 4;
  localparam int SETTLE = 60;
  localparam int TRIES  = 3;
  localparam int WCYC   = 40;
  // {words, corrupted echoes, busy polls, error expected}
  localparam int CASES [4][4] = '{
    '{40, 0, 2, 0},
    '{32, 1, 0, 0},
    '{ 1, 2, 1, 0},
    '{ 5, 3, 0, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b1;
  logic v0 = 1'b0, l0 = 1'b0, v1 = 1'b0, l1 = 1'b0;
  logic [15:0] d0 = '0, d1 = '0;
  logic rdy0, trst0, sck0, mosi0, miso0, done0, err0;
  logic rdy1, trst1, sck1, mosi1, miso1, done1, err1;
  int bad0 = 0, busy0 = 0, bad1 = 0, busy1 = 0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_fr [256];
  int n_exp;

  always #5 clk = ~clk;

  isp_host_seq #(.SCK_HALF(HALF), .RST_PULSE(RSTP), .SETTLE_CYC(SETTLE),
    .MAX_TRIES(TRIES), .WRITE_CYC(WCYC), .USE_POLL(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v0), .in_data_i(d0), .in_last_i(l0),
    .in_ready_o(rdy0), .tgt_rst_o(trst0), .sck_o(sck0), .mosi_o(mosi0),
    .miso_i(miso0), .done_o(done0), .error_o(err0));

  isp_host_seq #(.SCK_HALF(HALF), .RST_PULSE(RSTP), .SETTLE_CYC(SETTLE),
    .MAX_TRIES(TRIES), .WRITE_CYC(WCYC), .USE_POLL(1'b0)) dut_fix (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v1), .in_data_i(d1), .in_last_i(l1),
    .in_ready_o(rdy1), .tgt_rst_o(trst1), .sck_o(sck1), .mosi_o(mosi1),
    .miso_i(miso1), .done_o(done1), .error_o(err1));

  tgt_model #(.HALF(HALF)) m0 (.clk(clk), .clr(clr), .trst(trst0), .sck(sck0),
    .mosi(mosi0), .bad_n(bad0), .busy_n(busy0), .miso(miso0));
  tgt_model #(.HALF(HALF)) m1 (.clk(clk), .clr(clr), .trst(trst1), .sck(sck1),
    .mosi(mosi1), .bad_n(bad1), .busy_n(busy1), .miso(miso1));

  function automatic logic [15:0] wdat(int c, int i);
    return 16'(i * 4951 + c * 7919 + 16'h1A2B);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, expv, expv);
    end
  endtask

  task automatic feed(bit which, int c, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which) begin v1 = 1'b1; d1 = wdat(c, i); l1 = (i == n - 1); end
      else       begin v0 = 1'b1; d0 = wdat(c, i); l0 = (i == n - 1); end
      while (!(which ? rdy1 : rdy0)) @(negedge clk);
      @(negedge clk);
      v0 = 1'b0; v1 = 1'b0;
    end
  endtask

  task automatic wait_end(bit which);
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      if (which ? (done1 || err1) : (done0 || err0)) break;
    end
  endtask

  task automatic build_exp(int c, int n, int bad, int busy, bit experr, bit poll);
    int ne;
    ne = experr ? TRIES : bad + 1;
    n_exp = 0;
    for (int e = 0; e < ne; e++) exp_fr[n_exp++] = 32'hAC530000;
    if (!experr) begin
      for (int i = 0; i < n; i++) begin
        exp_fr[n_exp++] = {8'h40, 8'h00, 8'(i % 32), wdat(c, i)[7:0]};
        exp_fr[n_exp++] = {8'h48, 8'h00, 8'(i % 32), wdat(c, i)[15:8]};
        if (i % 32 == 31 || i == n - 1) begin
          exp_fr[n_exp++] = {8'h4C, 16'(i & ~31), 8'h00};
          if (poll) for (int p = 0; p <= busy; p++) exp_fr[n_exp++] = 32'hF0000000;
        end
      end
    end
  endtask

  task automatic run_case(bit which, int c, int n, int bad, int busy, bit experr);
    int nf, bad_at;
    @(negedge clk);
    rst_n = 1'b0; clr = 1'b1;
    bad0 = bad; busy0 = busy; bad1 = bad; busy1 = busy;
    repeat (3) @(negedge clk);
    // R1: outputs held inactive in reset
    chk((which ? trst1 : trst0) == 1'b0, "R1", "tgt_rst in reset", which ? trst1 : trst0, 0);
    chk((which ? sck1 : sck0) == 1'b0, "R1", "sck in reset", which ? sck1 : sck0, 0);
    chk((which ? rdy1 : rdy0) == 1'b0, "R1", "ready in reset", which ? rdy1 : rdy0, 0);
    chk((which ? (done1 | err1) : (done0 | err0)) == 1'b0, "R1", "done/err in reset",
        which ? (done1 | err1) : (done0 | err0), 0);
    clr = 1'b0; rst_n = 1'b1;
    if (!experr) begin
      feed(which, c, n);
      wait_end(which);
      chk(which ? (done1 && !err1) : (done0 && !err0), "R11", "done raised",
          which ? done1 : done0, 1);
    end else begin
      @(negedge clk); v0 = 1'b1; d0 = 16'h1234; l0 = 1'b1;
      wait_end(which);
      chk(err0 && !done0, "R5", "error after exhausted attempts", err0, 1);
    end
    nf = which ? m1.nfr : m0.nfr;
    repeat (200) @(negedge clk);
    chk((which ? m1.nfr : m0.nfr) == nf, "R5 R11", "no frames after end",
        which ? m1.nfr : m0.nfr, nf);
    chk((which ? rdy1 : rdy0) == 1'b0, "R5 R11", "ready low after end", which ? rdy1 : rdy0, 0);
    chk(which ? done1 || err1 : done0 || err0, "R5 R11", "end flag sticky", 1'b0, 1);
    v0 = 1'b0;
    build_exp(c, n, bad, busy, experr, !which);
    chk(nf == n_exp, "R4 R6 R7 R8", "frame count", nf, n_exp);
    bad_at = -1;
    for (int k = 0; k < n_exp && k < nf; k++)
      if ((which ? m1.frames[k] : m0.frames[k]) !== exp_fr[k] && bad_at < 0) bad_at = k;
    chk(bad_at < 0, "R4 R6 R7 R8", "frame content",
        bad_at < 0 ? 0 : int'(which ? m1.frames[bad_at] : m0.frames[bad_at]),
        bad_at < 0 ? 0 : int'(exp_fr[bad_at]));
    chk((which ? m1.pulses : m0.pulses) == (experr ? TRIES : bad + 1), "R2 R5",
        "reset pulses", which ? m1.pulses : m0.pulses, experr ? TRIES : bad + 1);
    chk((which ? m1.pw_min : m0.pw_min) == RSTP && (which ? m1.pw_max : m0.pw_max) == RSTP,
        "R2", "pulse width", which ? m1.pw_max : m0.pw_max, RSTP);
    chk((which ? m1.rs_bad : m0.rs_bad) == 0, "R2", "sck high during reset",
        which ? m1.rs_bad : m0.rs_bad, 0);
    chk((which ? m1.st_min : m0.st_min) >= SETTLE, "R3", "settle gap",
        which ? m1.st_min : m0.st_min, SETTLE);
    chk((which ? m1.hi_bad : m0.hi_bad) == 0, "R10", "sck high length errors",
        which ? m1.hi_bad : m0.hi_bad, 0);
    chk((which ? m1.mc_bad : m0.mc_bad) == 0, "R10", "mosi moved with sck high",
        which ? m1.mc_bad : m0.mc_bad, 0);
    if (which) chk(m1.wg_min >= WCYC, "R9", "write wait gap", m1.wg_min, WCYC);
  endtask

  initial begin
    for (int c = 0; c < 4; c++)
      run_case(1'b0, c, CASES[c][0], CASES[c][1], CASES[c][2], CASES[c][3] != 0);
    // R9: fixed write-time variant, target claims busy but is never polled
    run_case(1'b1, 4, 33, 0, 3, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule